// File: doc/BRIEF.md
# Low-Power I/O Pad State Controller

This block sits between a group of port pins and the pad cells of a small microcontroller. It decides, pin by pin, what the pads drive and what the core sees. It bases that decision on the current power mode, a policy bit for stop mode, and per-pin configuration. In run mode the port's output value, output enable, pull-up setting and the pad input pass straight through.

In the standby modes the block changes how the pads behave. It freezes the last driven output state. It can switch off the input gates, or leave them on and simply ignore what they report. It can also release the drivers to high impedance. The inputs it cuts off or ignores are forced to a constant 0 inside the chip, so a floating pad cannot toggle internal logic.

Some pins are able to raise interrupts. Software can exempt these pins from input cut-off in stop mode so that they can still wake the device. Pins on one designated port lose their pull-up in stop mode. The power-mode sequencer, clock gating and the analog pad behaviour are outside this block. The mode arrives as a plain 2-bit code, and all control pins are level signals with no handshake.

Top module: `pad_lp_ctrl`

## Requirements
- R1: With mode code 2'b00 (run), pad_out equals out_val, pad_oe equals out_en, in_gate_en is all ones, in_val equals pad_in, and pu_en equals pu_cfg, all in the same cycle.
- R2: With mode code 2'b01 (sleep), pad_out and pad_oe show the out_val and out_en values sampled at the last rising clock edge in run mode. in_gate_en is all ones and in_val is all zeros, so the gate stays on but the input is ignored.
- R3: With mode code 2'b10 (stop) and hiz_sel at 0, pad_out and pad_oe show the held run values. in_gate_en and in_val are zero for every pin that is not woken under R6.
- R4: With mode code 2'b10 and hiz_sel at 1, pad_oe and pad_out are all zeros. in_gate_en and in_val are zero for every pin that is not woken under R6.
- R5: When mode code is 2'b11 or rst_n is low, pad_oe, pad_out, in_val and pu_en are all zeros and in_gate_en is all ones. This rule takes priority over every other mode and over hiz_sel.
- R6: In stop mode, a pin whose WAKE_MASK bit is 1 and whose irq_sel bit is 1 has in_gate_en at 1 and in_val equal to pad_in. Its outputs still follow R3 or R4. Any other pin, and every pin in other modes, ignores irq_sel.
- R7: In stop mode, pu_en is 0 for every pin whose PU_KILL_MASK bit is 1, regardless of pu_cfg. The other pins follow pu_cfg.
- R8: While the mode is not run, changes on out_val and out_en have no effect on pad_out or pad_oe.
- R9: When the mode returns to run, pass-through per R1 resumes in the same cycle, with no extra clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that samples the output state to hold |
| rst_n | input | 1 | Active-low asynchronous reset; also forces the reset pad state |
| mode | input | 2 | Power mode: 00 run, 01 sleep, 10 stop/watch/timebase, 11 reset |
| hiz_sel | input | 1 | Stop-mode policy: 0 hold outputs, 1 release to high impedance |
| out_val | input | NPINS | Output value from the port or peripheral |
| out_en | input | NPINS | Output enable from the port or peripheral |
| irq_sel | input | NPINS | Per-pin external interrupt select (wake exemption) |
| pu_cfg | input | NPINS | Per-pin pull-up configuration |
| pad_in | input | NPINS | Raw value seen at the pad |
| pad_out | output | NPINS | Value driven onto the pad |
| pad_oe | output | NPINS | Pad driver enable |
| in_gate_en | output | NPINS | Pad input gate enable |
| in_val | output | NPINS | Input value presented to the core |
| pu_en | output | NPINS | Pull-up enable to the pad |

## Verification
The assertions take for granted that `mode` and `hiz_sel` change only between clock edges and stay at a legal 2-bit code. They also assume that a standby episode always starts after at least one edge in run mode following reset, or else the held state is the cleared reset value. The stimulus moves every input shortly after a falling edge, so each new mode is seen by exactly one rising edge before the next change. The bench sets up each standby entry with a distinct run pattern, so a wrongly captured held value shows up at the pads.

// File: rtl/pad_pkg.sv
package pad_pkg;

  typedef enum logic [1:0] {
    PM_RUN   = 2'b00,
    PM_SLEEP = 2'b01,
    PM_STOP  = 2'b10,
    PM_RESET = 2'b11
  } pmode_e;

  typedef struct packed {
    logic use_hold;   // drive frozen output state
    logic drive_off;  // release drivers, Hi-Z
    logic gate_on;    // input gate powered
    logic accept;     // core accepts pad value
    logic in_stop;    // stop/watch/timebase standby
    logic pu_off;     // all pull-ups forced off
  } pad_policy_t;

endpackage

// File: rtl/pad_mode_decode.sv
module pad_mode_decode
  import pad_pkg::*;
(
  input  logic        rst_n,
  input  logic [1:0]  mode,
  input  logic        hiz_sel,
  output pad_policy_t pol
);

  always_comb begin
    pol = '0;
    if (!rst_n || mode == PM_RESET) begin
      pol.drive_off = 1'b1;
      pol.gate_on   = 1'b1;
      pol.pu_off    = 1'b1;
    end else begin
      unique case (mode)
        PM_RUN: begin
          pol.gate_on = 1'b1;
          pol.accept  = 1'b1;
        end
        PM_SLEEP: begin
          pol.use_hold = 1'b1;
          pol.gate_on  = 1'b1;
        end
        default: begin
          pol.in_stop   = 1'b1;
          pol.use_hold  = !hiz_sel;
          pol.drive_off = hiz_sel;
        end
      endcase
    end
  end

endmodule

// File: rtl/pad_hold_reg.sv
module pad_hold_reg #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [NPINS-1:0] d_val,
  input  logic [NPINS-1:0] d_oe,
  output logic [NPINS-1:0] q_val,
  output logic [NPINS-1:0] q_oe
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_val <= '0;
      q_oe  <= '0;
    end else if (capture) begin
      q_val <= d_val;
      q_oe  <= d_oe;
    end
  end

  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> ($stable(q_val) && $stable(q_oe))); // R8

endmodule

// File: rtl/pad_pin_ctl.sv
module pad_pin_ctl
  import pad_pkg::*;
#(
  parameter bit WAKE_CAP = 1'b0,
  parameter bit PU_KILL  = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  pad_policy_t pol,
  input  logic        o_val,
  input  logic        o_en,
  input  logic        h_val,
  input  logic        h_en,
  input  logic        irq,
  input  logic        pu_in,
  input  logic        pin,
  output logic        p_out,
  output logic        p_oe,
  output logic        p_gate,
  output logic        p_in,
  output logic        p_pu
);

  logic wake;

  always_comb begin
    wake   = pol.in_stop & WAKE_CAP & irq;
    p_out  = pol.drive_off ? 1'b0 : (pol.use_hold ? h_val : o_val);
    p_oe   = pol.drive_off ? 1'b0 : (pol.use_hold ? h_en  : o_en);
    p_gate = pol.gate_on | wake;
    p_in   = (pol.accept | wake) & pin;
    if (pol.pu_off || (pol.in_stop && PU_KILL)) p_pu = 1'b0;
    else                                        p_pu = pu_in;
  end

  AST_CUTOFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !p_gate |-> !p_in); // R3

endmodule

// File: rtl/pad_lp_ctrl.sv
module pad_lp_ctrl
  import pad_pkg::*;
#(
  parameter int               NPINS        = 8,
  parameter logic [NPINS-1:0] WAKE_MASK    = 8'h0F,
  parameter logic [NPINS-1:0] PU_KILL_MASK = 8'hF0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             hiz_sel,
  input  logic [NPINS-1:0] out_val,
  input  logic [NPINS-1:0] out_en,
  input  logic [NPINS-1:0] irq_sel,
  input  logic [NPINS-1:0] pu_cfg,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] in_gate_en,
  output logic [NPINS-1:0] in_val,
  output logic [NPINS-1:0] pu_en
);

  pad_policy_t      pol;
  logic [NPINS-1:0] hold_val, hold_oe;
  logic             capture;

  assign capture = (mode == PM_RUN);

  pad_mode_decode u_dec (
    .rst_n   (rst_n),
    .mode    (mode),
    .hiz_sel (hiz_sel),
    .pol     (pol)
  );

  pad_hold_reg #(.NPINS(NPINS)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .d_val   (out_val),
    .d_oe    (out_en),
    .q_val   (hold_val),
    .q_oe    (hold_oe)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    pad_pin_ctl #(
      .WAKE_CAP (WAKE_MASK[i]),
      .PU_KILL  (PU_KILL_MASK[i])
    ) u_pin (
      .clk    (clk),
      .rst_n  (rst_n),
      .pol    (pol),
      .o_val  (out_val[i]),
      .o_en   (out_en[i]),
      .h_val  (hold_val[i]),
      .h_en   (hold_oe[i]),
      .irq    (irq_sel[i]),
      .pu_in  (pu_cfg[i]),
      .pin    (pad_in[i]),
      .p_out  (pad_out[i]),
      .p_oe   (pad_oe[i]),
      .p_gate (in_gate_en[i]),
      .p_in   (in_val[i]),
      .p_pu   (pu_en[i])
    );
  end

  AST_RESET_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_RESET) |-> (pad_oe == '0 && in_val == '0 && in_gate_en == '1 && pu_en == '0)); // R5
  AST_STOP_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_STOP && hiz_sel) |-> (pad_oe == '0 && pad_out == '0)); // R4
  AST_SLEEP_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_SLEEP && $past(mode) == PM_SLEEP) |-> ($stable(pad_out) && $stable(pad_oe))); // R2
  AST_SLEEP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_SLEEP) |-> (in_val == '0 && in_gate_en == '1)); // R2
  AST_WAKE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_STOP) |-> (((in_val ^ pad_in) & irq_sel & WAKE_MASK) == '0)); // R6
  AST_PU_KILL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_STOP) |-> ((pu_en & PU_KILL_MASK) == '0)); // R7

endmodule

// File: tb/tb_pad_lp_ctrl.sv
module tb_pad_lp_ctrl;

  localparam int         CLK_PERIOD = 10;
  localparam int         N    = 8;
  localparam logic [7:0] WAKE = 8'h0F;
  localparam logic [7:0] KILL = 8'hF0;

  typedef struct {
    logic [7:0] po, oe, ge, iv, pu;
    string      req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic hiz_sel = 1'b0;
  logic [7:0] out_val = '0, out_en = '0, irq_sel = '0, pu_cfg = '0, pad_in = '0;
  logic [7:0] pad_out, pad_oe, in_gate_en, in_val, pu_en;

  int checks = 0;
  int errors = 0;
  exp_t q[$];
  logic [7:0] b_hv = '0, b_ho = '0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pad_lp_ctrl #(.NPINS(N), .WAKE_MASK(WAKE), .PU_KILL_MASK(KILL)) dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .hiz_sel(hiz_sel),
    .out_val(out_val), .out_en(out_en), .irq_sel(irq_sel), .pu_cfg(pu_cfg),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .in_gate_en(in_gate_en), .in_val(in_val), .pu_en(pu_en)
  );

  function automatic exp_t model(string req);
    exp_t e;
    e.req = req;
    if (!rst_n || mode == 2'b11) begin
      e.po = '0; e.oe = '0; e.ge = '1; e.iv = '0; e.pu = '0;
    end else if (mode == 2'b00) begin
      e.po = out_val; e.oe = out_en; e.ge = '1; e.iv = pad_in; e.pu = pu_cfg;
    end else if (mode == 2'b01) begin
      e.po = b_hv; e.oe = b_ho; e.ge = '1; e.iv = '0; e.pu = pu_cfg;
    end else begin
      e.po = hiz_sel ? 8'h00 : b_hv;
      e.oe = hiz_sel ? 8'h00 : b_ho;
      e.ge = irq_sel & WAKE;
      e.iv = pad_in & irq_sel & WAKE;
      e.pu = pu_cfg & ~KILL;
    end
    return e;
  endfunction

  task automatic step(input logic rn, input logic [1:0] m, input logic hz,
                      input logic [7:0] ov, input logic [7:0] oe,
                      input logic [7:0] irq, input logic [7:0] pu,
                      input logic [7:0] pin, input string req);
    @(negedge clk);
    rst_n = rn; mode = m; hiz_sel = hz;
    out_val = ov; out_en = oe; irq_sel = irq; pu_cfg = pu; pad_in = pin;
    #1;
    q.push_back(model(req));
    if (!rn) begin
      b_hv = '0; b_ho = '0;
    end else if (m == 2'b00) begin
      b_hv = ov; b_ho = oe;
    end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      wait (q.size() > 0);
      e = q.pop_front();
      checks++;
      if (pad_out !== e.po || pad_oe !== e.oe || in_gate_en !== e.ge ||
          in_val !== e.iv || pu_en !== e.pu) begin
        errors++;
        $display("FAIL %s: got out=%h oe=%h gate=%h in=%h pu=%h exp out=%h oe=%h gate=%h in=%h pu=%h",
                 e.req, pad_out, pad_oe, in_gate_en, in_val, pu_en,
                 e.po, e.oe, e.ge, e.iv, e.pu);
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    step(1'b0, 2'b00, 1'b0, 8'hA5, 8'h3C, 8'h00, 8'hFF, 8'h96, "R5 reset pin low");
    step(1'b1, 2'b00, 1'b0, 8'hA5, 8'h3C, 8'h00, 8'hFF, 8'h96, "R1 run pass");
    step(1'b1, 2'b00, 1'b0, 8'h5A, 8'hFF, 8'h00, 8'h0F, 8'h69, "R1 run pass b");
    step(1'b1, 2'b01, 1'b0, 8'h00, 8'h00, 8'h00, 8'hFF, 8'hFF, "R2 sleep hold");
    step(1'b1, 2'b01, 1'b0, 8'hFF, 8'h0F, 8'hFF, 8'hFF, 8'h0F, "R8 sleep ignores out, R6 no wake");
    step(1'b1, 2'b00, 1'b0, 8'hC3, 8'h0F, 8'h00, 8'hAA, 8'h33, "R9 back to run");
    step(1'b1, 2'b10, 1'b0, 8'h00, 8'hFF, 8'h00, 8'hFF, 8'hFF, "R3 stop hold, R7 pull-up");
    step(1'b1, 2'b10, 1'b0, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'hA5, "R6 wake pins, R8");
    step(1'b1, 2'b10, 1'b1, 8'hFF, 8'hFF, 8'h05, 8'h3C, 8'hFF, "R4 stop hiz, R6");
    step(1'b1, 2'b10, 1'b1, 8'hFF, 8'hFF, 8'hF0, 8'hFF, 8'hFF, "R6 non-wake irq ignored");
    step(1'b1, 2'b11, 1'b1, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, "R5 reset mode");
    step(1'b1, 2'b00, 1'b0, 8'h81, 8'h7E, 8'h00, 8'h55, 8'hC6, "R9 run after reset");
    step(1'b1, 2'b10, 1'b0, 8'h00, 8'h00, 8'h0A, 8'hFF, 8'h0E, "R3 hold new pattern, R6");
    step(1'b0, 2'b10, 1'b1, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, "R5 reset priority");
    step(1'b1, 2'b01, 1'b0, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'hFF, "R2 sleep after reset cleared");
    step(1'b1, 2'b00, 1'b0, 8'h12, 8'h34, 8'h00, 8'h56, 8'h78, "R1 run final");
    @(negedge clk);
    wait (q.size() == 0);
    #1;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule